// File: doc/BRIEF.md
# Two-Wire Serial Programming Port Target

This block is the target side of a two-wire serial programming link. An external host drives a serial clock line and a data line. The target samples the data line on falling clock edges and drives it only inside the output window of a read frame. Both lines are resynchronised into the system clock domain, so the serial clock may run at any rate well below the system clock. Every frame is exactly 20 serial clocks long: a 4-bit command arrives least-significant bit first, followed by 16 payload clocks.

Two commands exist. The "core step" command carries a 16-bit instruction word. The block acts on only a tiny instruction subset: load an 8-bit literal into a working byte, copy that byte into one of the three bytes of a 22-bit table pointer, or do nothing. The "table fetch" command reads one byte through a simple memory port into a table latch and advances the pointer. The block ignores the first 8 payload clocks of this command and turns the data line around after the 8th of them. It then shifts the byte out least-significant bit first on the next 8 rising edges and releases the line at the end of the frame.

Top module: `prgport_top`

## Requirements
- R1: After reset the output enable is low, no memory read is pending, and the table pointer is 0, so the first fetch reads address 0.
- R2: A frame is 20 serial clocks counted by falling edges. The command is the first 4 bits, least-significant bit first. The next frame starts on the 21st falling edge, whatever the command was.
- R3: Under command value 0 (core step), payload word 0x0E followed by an 8-bit literal (literal in bits 7:0) loads that literal into the working byte. The payload is received least-significant bit first.
- R4: Core-step words 0x6EF8, 0x6EF7 and 0x6EF6 copy the working byte into pointer bits 21:16, 15:8 and 7:0. For bits 21:16 only the low 6 bits of the working byte are used.
- R5: Command value 9 (table fetch) issues exactly one single-cycle memory read at the current pointer after the 4th command bit. The read data is taken one cycle after the read strobe.
- R6: During a fetch, the output enable rises after the 12th falling edge of the frame (the 8th payload clock) and not before it. It stays high until the 20th falling edge and then drops.
- R7: The fetched byte appears on the data output least-significant bit first. Each bit changes on a rising serial edge, from payload clock 9 to payload clock 16.
- R8: Each fetch adds one to the 22-bit pointer, and 0x3FFFFF wraps to 0.
- R9: A command other than 0 or 9 never raises the output enable, issues no memory read and leaves the pointer unchanged.
- R10: A core-step word outside the recognised set, and the no-op word 0x0000, leave both the working byte and the pointer unchanged.
- R11: The serial clock may be held low for any length of time at the turnaround point without changing the fetched byte or the output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock driven by the host |
| sdat_i | input | 1 | Serial data from the host |
| sdat_o | output | 1 | Serial data toward the host |
| sdat_oe_o | output | 1 | Drive enable for the data line |
| mem_rd_o | output | 1 | Single-cycle memory read strobe |
| mem_addr_o | output | 22 | Memory byte address |
| mem_rdata_i | input | 8 | Read byte, valid the cycle after the strobe |

## Verification
The assertions rely on the host keeping every serial clock phase several system clocks long. This makes each falling edge and each rising edge show up as a separate one-cycle event after the synchronisers. They also rely on the memory returning data exactly one cycle after the strobe. The bench holds each serial phase for eight system cycles and changes data only while the serial clock is high. Its memory model registers a byte on every strobe. During a fetch it holds the data input low from the start of the payload onward, so the host is never driving against the target.

// File: rtl/prgport_pkg.sv
package prgport_pkg;
  localparam int CMD_W     = 4;
  localparam int PAY_W     = 16;
  localparam int IDLE_CLKS = 8;
  localparam int FRAME_LEN = CMD_W + PAY_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);

  localparam logic [CMD_W-1:0] CMD_CORE  = 4'b0000;
  localparam logic [CMD_W-1:0] CMD_TBLRD = 4'b1001;

  typedef enum logic [2:0] {
    OP_NOP, OP_LDW, OP_STU, OP_STH, OP_STL, OP_IGN
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [7:0] lit;
  } insn_t;

  // Map a 16-bit instruction word onto the tiny supported subset.
  function automatic insn_t decode_insn(input logic [PAY_W-1:0] w);
    insn_t d;
    d.lit = w[7:0];
    d.op  = OP_IGN;
    if (w == 16'h0000)          d.op = OP_NOP;
    else if (w[15:8] == 8'h0E)  d.op = OP_LDW;
    else if (w == 16'h6EF8)     d.op = OP_STU;
    else if (w == 16'h6EF7)     d.op = OP_STH;
    else if (w == 16'h6EF6)     d.op = OP_STL;
    return d;
  endfunction
endpackage

// File: rtl/prgport_edge.sv
module prgport_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdat_i,
  output logic fall_o,
  output logic rise_o,
  output logic dat_o
);
  logic [STAGES-1:0] clk_sync;
  logic [STAGES-1:0] dat_sync;
  logic              clk_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sync <= '0;
      dat_sync <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_sync <= {clk_sync[STAGES-2:0], sclk_i};
      dat_sync <= {dat_sync[STAGES-2:0], sdat_i};
      clk_prev <= clk_sync[STAGES-1];
    end
  end

  assign fall_o = clk_prev & ~clk_sync[STAGES-1];
  assign rise_o = ~clk_prev & clk_sync[STAGES-1];
  assign dat_o  = dat_sync[STAGES-1];
endmodule

// File: rtl/prgport_frame.sv
module prgport_frame
  import prgport_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             rise_i,
  input  logic             dat_i,
  input  logic [7:0]       latch_i,
  output logic             cmd_ev_o,
  output logic             frame_ev_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [PAY_W-1:0] pay_o,
  output logic             sdat_o,
  output logic             oe_o
);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CMD_N    = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] OE_AT    = CNT_W'(CMD_W + IDLE_CLKS - 1);
  localparam logic [CNT_W-1:0] OE_ON    = CNT_W'(CMD_W + IDLE_CLKS);

  logic [CNT_W-1:0] fcnt;
  logic [CMD_W-1:0] cmd_sr;
  logic [PAY_W-1:0] pay_sr;
  logic [7:0]       tx_sr;
  logic             oe_q;
  logic             sdat_q;
  logic             cmd_ev_q;
  logic             frame_ev_q;
  logic             is_fetch;

  assign is_fetch = (cmd_sr == CMD_TBLRD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt       <= '0;
      cmd_sr     <= '0;
      pay_sr     <= '0;
      tx_sr      <= '0;
      oe_q       <= 1'b0;
      sdat_q     <= 1'b0;
      cmd_ev_q   <= 1'b0;
      frame_ev_q <= 1'b0;
    end else begin
      cmd_ev_q   <= fall_i && (fcnt == CMD_LAST);
      frame_ev_q <= fall_i && (fcnt == LAST);
      if (fall_i) begin
        fcnt <= (fcnt == LAST) ? '0 : fcnt + 1'b1;
        if (fcnt < CMD_N) cmd_sr <= {dat_i, cmd_sr[CMD_W-1:1]};
        else              pay_sr <= {dat_i, pay_sr[PAY_W-1:1]};
        if (fcnt == OE_AT && is_fetch) begin
          oe_q  <= 1'b1;
          tx_sr <= latch_i;
        end
        if (fcnt == LAST) oe_q <= 1'b0;
      end
      if (rise_i && oe_q) begin
        sdat_q <= tx_sr[0];
        tx_sr  <= {1'b0, tx_sr[7:1]};
      end
    end
  end

  assign cmd_ev_o   = cmd_ev_q;
  assign frame_ev_o = frame_ev_q;
  assign cmd_o      = cmd_sr;
  assign pay_o      = pay_sr;
  assign sdat_o     = sdat_q;
  assign oe_o       = oe_q;

  p_frame_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && fcnt == LAST) |=> (fcnt == '0));
  p_oe_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> (fcnt == OE_ON));
  p_oe_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_q) |-> (fcnt == '0));
  p_oe_cmd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (cmd_sr == CMD_TBLRD));
  p_tx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(sdat_q));
endmodule

// File: rtl/prgport_table.sv
module prgport_table
  import prgport_pkg::*;
#(
  parameter int PTR_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_ev_i,
  input  logic             frame_ev_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [PAY_W-1:0] pay_i,
  input  logic [7:0]       mem_rdata_i,
  output logic             mem_rd_o,
  output logic [PTR_W-1:0] mem_addr_o,
  output logic [7:0]       latch_o
);
  localparam int UP_W = PTR_W - 16;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  logic [PTR_W-1:0] ptr_q;
  logic [7:0]       wreg;
  logic [7:0]       latch_q;
  logic             rd_q;
  logic             rd_pend;
  logic [PTR_W-1:0] addr_q;
  logic             rd_go;
  logic             exec_go;
  insn_t            insn;

  assign rd_go   = cmd_ev_i && (cmd_i == CMD_TBLRD);
  assign exec_go = frame_ev_i && (cmd_i == CMD_CORE);
  assign insn    = decode_insn(pay_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      wreg    <= '0;
      latch_q <= '0;
      rd_q    <= 1'b0;
      rd_pend <= 1'b0;
      addr_q  <= '0;
    end else begin
      rd_q    <= rd_go;
      rd_pend <= rd_q;
      if (rd_go) begin
        addr_q <= ptr_q;
        ptr_q  <= ptr_step(ptr_q);
      end
      if (rd_pend) latch_q <= mem_rdata_i;
      if (exec_go) begin
        case (insn.op)
          OP_LDW:  wreg <= insn.lit;
          OP_STU:  ptr_q[PTR_W-1:16] <= wreg[UP_W-1:0];
          OP_STH:  ptr_q[15:8] <= wreg;
          OP_STL:  ptr_q[7:0]  <= wreg;
          default: ;
        endcase
      end
    end
  end

  assign mem_rd_o   = rd_q;
  assign mem_addr_o = addr_q;
  assign latch_o    = latch_q;

  p_rd_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
  p_ptr_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (ptr_q == ptr_step(mem_addr_o)));
  p_latch_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend |=> (latch_q == $past(mem_rdata_i)));
  p_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_go && (insn.op == OP_IGN || insn.op == OP_NOP)) |=> ($stable(wreg) && $stable(ptr_q)));
endmodule

// File: rtl/prgport_top.sv
module prgport_top
  import prgport_pkg::*;
#(
  parameter int PTR_W       = 22,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             sdat_i,
  output logic             sdat_o,
  output logic             sdat_oe_o,
  output logic             mem_rd_o,
  output logic [PTR_W-1:0] mem_addr_o,
  input  logic [7:0]       mem_rdata_i
);
  logic             fall_ev;
  logic             rise_ev;
  logic             dat_s;
  logic             cmd_ev;
  logic             frame_ev;
  logic [CMD_W-1:0] cmd_w;
  logic [PAY_W-1:0] pay_w;
  logic [7:0]       latch_w;

  prgport_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .sdat_i (sdat_i),
    .fall_o (fall_ev),
    .rise_o (rise_ev),
    .dat_o  (dat_s)
  );

  prgport_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_i     (fall_ev),
    .rise_i     (rise_ev),
    .dat_i      (dat_s),
    .latch_i    (latch_w),
    .cmd_ev_o   (cmd_ev),
    .frame_ev_o (frame_ev),
    .cmd_o      (cmd_w),
    .pay_o      (pay_w),
    .sdat_o     (sdat_o),
    .oe_o       (sdat_oe_o)
  );

  prgport_table #(.PTR_W(PTR_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_ev_i    (cmd_ev),
    .frame_ev_i  (frame_ev),
    .cmd_i       (cmd_w),
    .pay_i       (pay_w),
    .mem_rdata_i (mem_rdata_i),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .latch_o     (latch_w)
  );
endmodule

// File: tb/prgport_top_tb_top.sv
`timescale 1ns/1ps
module prgport_top_tb_top;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        sdat = 1'b0;
  logic        sdat_o, sdat_oe, mem_rd;
  logic [21:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;

  int nchk = 0, nfail = 0, rd_cnt = 0;
  bit done = 1'b0;
  logic [21:0] last_addr = '0;
  logic [21:0] ptr_m = '0;
  logic [7:0]  w_m = '0;
  logic [7:0]  exp_q[$];
  logic [7:0]  got_byte;
  event        byte_ev;

  always #10 clk = ~clk;

  prgport_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdat_i(sdat),
    .sdat_o(sdat_o), .sdat_oe_o(sdat_oe), .mem_rd_o(mem_rd),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] mem_byte(input logic [21:0] a);
    return (a[7:0] + 8'h3C) ^ a[15:8] ^ {2'b00, a[21:16]};
  endfunction

  always @(posedge clk) if (mem_rd) begin
    mem_rdata <= mem_byte(mem_addr);
    last_addr <= mem_addr;
    rd_cnt    <= rd_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    sclk = 1'b1; sdat = b; wait_cyc(HALF);
    sclk = 1'b0; wait_cyc(HALF);
  endtask

  task automatic send_raw(input logic [3:0] cmd, input logic [15:0] word);
    for (int i = 0; i < 4; i++) pulse(cmd[i]);
    for (int i = 0; i < 16; i++) pulse(word[i]);
    sdat = 1'b0;
  endtask

  // Core step with a bench-side model of the instruction subset (R3, R4, R10)
  task automatic core(input logic [15:0] word);
    send_raw(4'b0000, word);
    wait_cyc(4);
    if (word[15:8] == 8'h0E) w_m = word[7:0];
    else if (word == 16'h6EF8) ptr_m[21:16] = w_m[5:0];
    else if (word == 16'h6EF7) ptr_m[15:8] = w_m;
    else if (word == 16'h6EF6) ptr_m[7:0] = w_m;
  endtask

  task automatic set_ptr(input logic [21:0] a);
    core({8'h0E, 2'b00, a[21:16]}); core(16'h6EF8);
    core({8'h0E, a[15:8]});         core(16'h6EF7);
    core({8'h0E, a[7:0]});          core(16'h6EF6);
  endtask

  // Scoreboard driver: pushes expected byte, runs the fetch frame
  task automatic fetch(input int hold);
    logic [7:0]  got;
    logic [21:0] ea;
    int          rd0;
    ea  = ptr_m;
    rd0 = rd_cnt;
    exp_q.push_back(mem_byte(ea));
    ptr_m = ptr_m + 22'd1;
    for (int i = 0; i < 4; i++) pulse(4'b1001 >> i);
    for (int i = 0; i < 7; i++) pulse(1'b0);
    check(sdat_oe == 1'b0, "R6 oe before 8th payload clock", sdat_oe, 0);
    check(rd_cnt == rd0 + 1, "R5 one read per fetch", rd_cnt - rd0, 1);
    check(last_addr == ea, "R5/R8 fetch address", last_addr, ea);
    pulse(1'b0);
    check(sdat_oe == 1'b1, "R6 oe after 8th payload clock", sdat_oe, 1);
    wait_cyc(hold);
    check(sdat_oe == 1'b1, "R11 oe held across turnaround", sdat_oe, 1);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b1; wait_cyc(HALF);
      got[i] = sdat_o;
      sclk = 1'b0; wait_cyc(HALF);
    end
    check(sdat_oe == 1'b0, "R6 oe released after frame", sdat_oe, 0);
    got_byte = got;
    -> byte_ev;
  endtask

  // Scoreboard monitor (R7)
  initial forever begin
    logic [7:0] e;
    @(byte_ev);
    e = exp_q.pop_front();
    check(got_byte == e, "R7 fetched byte LSB first", got_byte, e);
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL R2 watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int rd0;
    wait_cyc(5);
    check(sdat_oe == 1'b0 && mem_rd == 1'b0, "R1 reset outputs", {sdat_oe, mem_rd}, 0);
    rst_n = 1'b1;
    wait_cyc(5);
    check(sdat_oe == 1'b0, "R1 oe low after reset", sdat_oe, 0);
    fetch(0);                               // R1 pointer starts at 0
    fetch(0);                               // R8 increment
    set_ptr(22'h123456);                    // R3, R4
    fetch(3);
    core(16'h0EFF); core(16'h6EF8);         // R4 upper takes 6 bits
    core(16'h6EF7); core(16'h6EF6);
    check(ptr_m == 22'h3FFFFF, "R4 model pointer", ptr_m, 22'h3FFFFF);
    fetch(0);                               // address 3FFFFF
    fetch(0);                               // R8 wrap to 0
    rd0 = rd_cnt;
    send_raw(4'b0101, 16'hFFFF);            // R9 unknown command
    check(sdat_oe == 1'b0, "R9 no drive on unknown command", sdat_oe, 0);
    check(rd_cnt == rd0, "R9 no read on unknown command", rd_cnt - rd0, 0);
    send_raw(4'b0110, 16'h0000);            // R9, R2 framing kept
    fetch(0);                               // R2, R9 pointer kept at 1
    core(16'h0EAA); core(16'h0F55);         // R10 unknown word
    core(16'h0000); core(16'h6EE6);         // R10 no-op and near miss
    core(16'h6EF6);
    check(ptr_m == 22'h0000AA, "R10 model pointer", ptr_m, 22'h0000AA);
    fetch(0);                               // expects address 0000AA
    fetch(250);                             // R11 long turnaround
    wait_cyc(20);
    check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule